// File: doc/BRIEF.md
# Multi-Mode Test Register

A single n-bit register that can play four roles in a self-testing datapath, chosen each clock by a 2-bit mode code. As a plain register it captures the parallel data bus. As a scan cell chain it shifts serially from a scan input toward the most significant stage, so a tester can preload or unload its contents. As a pattern source it runs as a linear feedback shift register with a programmable feedback polynomial. With the parallel bus held at zero it then steps through pseudo-random test vectors. As a response compactor it does the same recurrence while folding one parallel input bit into each stage. After a run it holds the remainder of the applied data stream divided modulo 2 by the polynomial, which serves as a signature.

A synchronous clear input and a seed-load mode start each run from a known state. The feedback is an internal-XOR form. The polynomial is given as a parameter that lists the tap terms below the leading term. The default is a primitive degree-8 polynomial. Choosing or comparing the expected signature is left to surrounding logic.

Top module: `tstreg_top`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `parOut` becomes all zeros, whatever `mode`, `parIn` and `scanIn` hold.
- R2: With `mode` = 2'b11 (capture) and `rst` = 0, `parOut` takes the value of `parIn` at the next edge.
- R3: With `mode` = 2'b00 (scan) and `rst` = 0, the next state is the current state shifted one place toward bit WIDTH-1, with `scanIn` entering bit 0.
- R4: `scanOut` always equals bit WIDTH-1 of `parOut`, in every mode.
- R5: With `mode` = 2'b01 (seed) and `rst` = 0, `parOut` takes the parameter SEED at the next edge.
- R6: With `mode` = 2'b10 (LFSR) and `rst` = 0, the next state is (state shifted one place toward bit WIDTH-1 with 0 into bit 0), XOR POLY if the current bit WIDTH-1 is 1, XOR `parIn`. POLY holds the coefficients of x^0 to x^(WIDTH-1), and bit 0 of POLY is 1.
- R7: For WIDTH=4 and POLY=4'b0011 (x^4+x+1), LFSR mode with `parIn` = 0 from a nonzero seed visits all 15 nonzero states once each and returns to the seed after 15 clocks, never reaching zero.
- R8: Starting from zero, a bit stream applied on `parIn[0]` in LFSR mode (other bits 0) leaves in the register the remainder of the stream, read first bit as the highest power, divided modulo 2 by the polynomial. A single flipped bit in the stream changes that remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high |
| mode | input | 2 | 00 scan, 01 seed, 10 LFSR, 11 capture |
| parIn | input | WIDTH | Parallel data, or compactor input in LFSR mode |
| scanIn | input | 1 | Serial input to bit 0 in scan mode |
| parOut | output | WIDTH | Register contents |
| scanOut | output | 1 | Most significant stage |

## Verification
The capture mode is swept over all 16 values of a 4-bit build. The LFSR step is checked exhaustively over every pair of current state and parallel input, which separates tap position errors, a missing feedback term and a dropped input fold. Scanning uses a flush pattern (single one in zeros) and a 0011 repeating pattern, so every bit-to-bit transfer 00, 01, 11 and 10 is seen. The generator is run for a full period to prove maximal length. A serial stream is compacted and compared with a long division, once plain and once with one bit flipped.

// File: rtl/tstreg_pkg.sv
package tstreg_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_SEED = 2'b01,
    MODE_LFSR = 2'b10,
    MODE_LOAD = 2'b11
  } modeT;

  typedef struct packed {
    logic clear;
    logic seedLoad;
    logic shiftEn;
    logic lfsrEn;
    logic parLoad;
  } strobeT;

endpackage

// File: rtl/tstreg_ctrl.sv
module tstreg_ctrl
  import tstreg_pkg::*;
(
  input  logic       rst,
  input  logic [1:0] mode,
  output strobeT     strobe
);

  always_comb begin
    strobe = '0;
    if (rst) begin
      strobe.clear = 1'b1;
    end else begin
      unique case (modeT'(mode))
        MODE_SCAN: strobe.shiftEn  = 1'b1;
        MODE_SEED: strobe.seedLoad = 1'b1;
        MODE_LFSR: strobe.lfsrEn   = 1'b1;
        MODE_LOAD: strobe.parLoad  = 1'b1;
        default:   strobe          = '0;
      endcase
    end
  end

endmodule

// File: rtl/tstreg_dp.sv
module tstreg_dp
  import tstreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1D,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  strobeT           strobe,
  input  logic [WIDTH-1:0] parIn,
  input  logic             scanIn,
  output logic [WIDTH-1:0] state
);

  localparam int unsigned MSB = WIDTH - 1;

  logic             feedback;
  logic [WIDTH-1:0] lfsrNext;
  logic [WIDTH-1:0] shiftNext;
  logic [WIDTH-1:0] stateNext;

  assign feedback = state[MSB];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : gStage
      if (i == 0) begin : gLow
        assign lfsrNext[i]  = (feedback & POLY[i]) ^ parIn[i];
        assign shiftNext[i] = scanIn;
      end else begin : gUpper
        assign lfsrNext[i]  = state[i-1] ^ (feedback & POLY[i]) ^ parIn[i];
        assign shiftNext[i] = state[i-1];
      end
    end
  endgenerate

  always_comb begin
    stateNext = state;
    if (strobe.clear)         stateNext = '0;
    else if (strobe.seedLoad) stateNext = SEED;
    else if (strobe.shiftEn)  stateNext = shiftNext;
    else if (strobe.lfsrEn)   stateNext = lfsrNext;
    else if (strobe.parLoad)  stateNext = parIn;
  end

  always_ff @(posedge clk) begin
    state <= stateNext;
  end

endmodule

// File: rtl/tstreg_top.sv
module tstreg_top
  import tstreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1D,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             scanIn,
  output logic [WIDTH-1:0] parOut,
  output logic             scanOut
);

  strobeT           strobe;
  logic [WIDTH-1:0] state;

  tstreg_ctrl uCtrl (
    .rst    (rst),
    .mode   (mode),
    .strobe (strobe)
  );

  tstreg_dp #(
    .WIDTH (WIDTH),
    .POLY  (POLY),
    .SEED  (SEED)
  ) uDp (
    .clk    (clk),
    .strobe (strobe),
    .parIn  (parIn),
    .scanIn (scanIn),
    .state  (state)
  );

  assign parOut  = state;
  assign scanOut = state[WIDTH-1];

endmodule

// File: rtl/tstreg_chk.sv
module tstreg_chk #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] parIn,
  input logic             scanIn,
  input logic [WIDTH-1:0] parOut,
  input logic             scanOut
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) rst |=> parOut == '0); // R1

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> parOut == $past(parIn)); // R2

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> parOut == {$past(parOut[WIDTH-2:0]), $past(scanIn)}); // R3

  AST_SCAN_OUT_MSB: assert property (@(posedge clk) disable iff (rst)
    scanOut == parOut[WIDTH-1]); // R4

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> parOut == SEED); // R5

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && parIn == '0 && parOut != '0) |=> parOut != '0); // R7

endmodule

bind tstreg_top tstreg_chk #(
  .WIDTH (WIDTH),
  .SEED  (SEED)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .parIn   (parIn),
  .scanIn  (scanIn),
  .parOut  (parOut),
  .scanOut (scanOut)
);

// File: tb/tstreg_top_test.sv
module tstreg_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam logic [W-1:0] TAPS = 4'b0011;
  localparam logic [W-1:0] SEEDV = 4'b0001;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] parIn = '0;
  logic         scanIn = 1'b0;
  logic [W-1:0] parOut;
  logic         scanOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstreg_top #(.WIDTH(W), .POLY(TAPS), .SEED(SEEDV)) uut (
    .clk(clk), .rst(rst), .mode(mode), .parIn(parIn),
    .scanIn(scanIn), .parOut(parOut), .scanOut(scanOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one edge pass, return at next negedge
  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] d, input logic s);
    rst = r; mode = m; parIn = d; scanIn = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] modelLfsr(input logic [W-1:0] cur, input logic [W-1:0] d);
    logic [W-1:0] nxt;
    nxt = cur << 1;
    if (cur[W-1]) nxt = nxt ^ TAPS;
    return nxt ^ d;
  endfunction

  // polynomial long division of a bit stream (first bit = highest power)
  function automatic logic [W-1:0] divRemainder(input logic [31:0] bits, input int n);
    logic [W:0] rem;
    rem = '0;
    for (int k = n - 1; k >= 0; k--) begin
      rem = {rem[W-1:0], bits[k]};
      if (rem[W]) rem = rem ^ {1'b1, TAPS};
    end
    return rem[W-1:0];
  endfunction

  task automatic compact(input logic [31:0] bits, input int n);
    step(1'b1, 2'b11, '0, 1'b0);
    for (int k = n - 1; k >= 0; k--) step(1'b0, 2'b10, {{(W-1){1'b0}}, bits[k]}, 1'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] expState;
    logic [15:0] seen;
    logic [31:0] stream;
    logic [W-1:0] sigA;
    @(negedge clk);

    // R1 reset state
    step(1'b1, 2'b11, 4'hF, 1'b1);
    check("R1 clear", parOut, 0);
    check("R4 scanOut after clear", scanOut, 0);

    // R5 seed
    step(1'b0, 2'b01, 4'hA, 1'b1);
    check("R5 seed load", parOut, SEEDV);

    // R2 capture sweep, R4 msb
    for (int v = 0; v < 16; v++) begin
      step(1'b0, 2'b11, v[W-1:0], 1'b0);
      check("R2 capture", parOut, v);
      check("R4 scanOut in capture", scanOut, v[W-1]);
    end

    // R1 clear while capture requested
    step(1'b1, 2'b11, 4'hF, 1'b1);
    check("R1 clear beats capture", parOut, 0);

    // R3 flush: single one through zeros
    expState = '0;
    for (int k = 0; k < 7; k++) begin
      step(1'b0, 2'b00, 4'hF, (k == 0));
      expState = {expState[W-2:0], (k == 0)};
      check("R3 flush shift", parOut, expState);
      check("R4 scanOut in scan", scanOut, expState[W-1]);
    end

    // R3 0011 repeating pattern from a loaded value
    step(1'b0, 2'b11, 4'hA, 1'b0);
    expState = 4'hA;
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 2'b00, '0, k[1]);
      expState = {expState[W-2:0], k[1]};
      check("R3 pattern shift", parOut, expState);
    end

    // R6 exhaustive step over state x input
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        step(1'b0, 2'b11, s[W-1:0], 1'b0);
        step(1'b0, 2'b10, d[W-1:0], 1'b0);
        check("R6 lfsr step", parOut, modelLfsr(s[W-1:0], d[W-1:0]));
      end
    end

    // R7 full period from seed
    step(1'b0, 2'b01, '0, 1'b0);
    seen = '0;
    seen[SEEDV] = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      step(1'b0, 2'b10, '0, 1'b0);
      if (k < 15) begin
        check("R7 state nonzero", (parOut != 0), 1);
        check("R7 state not revisited", seen[parOut], 0);
        seen[parOut] = 1'b1;
      end else begin
        check("R7 period 15 returns to seed", parOut, SEEDV);
      end
    end
    check("R7 all nonzero states seen", seen, 16'hFFFE);

    // R8 signature equals remainder
    stream = 32'h000B_6D35;
    compact(stream, 20);
    sigA = parOut;
    check("R8 signature remainder", sigA, divRemainder(stream, 20));
    compact(stream ^ 32'h0000_0100, 20);
    check("R8 flipped stream remainder", parOut, divRemainder(stream ^ 32'h0000_0100, 20));
    check("R8 single bit error detected", (parOut != sigA), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule